// File: doc/BRIEF.md
# Quantized Matrix-Vector-Threshold Engine

This block computes one fully connected layer of a low-precision neural network as a streaming engine. Each input vector holds `IN_DIM` unsigned 2-bit activations. They arrive `SIMD` at a time over a valid/ready stream and are multiplied against a fixed matrix of signed 2-bit weights held inside the engine. Each of the `OUT_DIM` dot products is reduced to a 2-bit output level by comparing it with three ascending thresholds. The levels leave `PE` at a time on a second valid/ready stream, so the next layer engine can consume them directly.

The matrix is folded over a `PE` x `SIMD` array. There are `OUT_DIM/PE` row folds and `IN_DIM/SIMD` column folds for each vector. Every processing element owns one output row per row fold and a private weight bank, so no weight traffic leaves the block. The input vector is captured once into a local buffer and reused for every row fold. The upstream stage is therefore held off only between the capture of one vector and the acceptance of its last output beat. A chain of such engines, with a final two-level layer, produces the fallen/non-fallen decision at the end of the network.

Top module: `qmvtu_engine`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: An input beat carries activation `b*SIMD+j` in bits `[2j+1:2j]` of `in_data`, where `b` is the beat index within the vector. A vector takes `IN_DIM/SIMD` accepted beats. In the cycle after its last beat is accepted, `in_ready` is low.
- R3: The weight for output row `r` and input column `c` has the code `(3*r + 5*c + SEED) mod 4`. The code decodes as 00 = 0, 01 = +1, 10 = -2 and 11 = -1.
- R4: Row `r` forms the signed sum over `c` of activation(c) x weight(r,c). Activations are unsigned values from 0 to 3.
- R5: The output level of a row is the number of thresholds among `THR_LO`, `THR_MID` and `THR_HI` that the sum is greater than or equal to. The levels are checked at elaboration to be strictly ascending.
- R6: Output beat `k` carries row `k*PE+p` in bits `[2p+1:2p]` of `out_data`. A vector produces `OUT_DIM/PE` beats in ascending `k`. `in_ready` returns high in the cycle after the last beat is accepted, and not before.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. Every result beat is delivered exactly once.
- R8: Cycles in which `in_valid` is low capture nothing. Gaps between the beats of a vector do not change the results.
- R9: `in_ready` and `out_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Engine accepts an input beat |
| in_data | input | 2*SIMD | SIMD packed unsigned activations |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 2*PE | PE packed 2-bit output levels |

## Verification
Two events can land in the same cycle: a row result first appearing on `out_valid`, and the downstream dropping `out_ready` at that moment. The bench drives `out_ready` from a random pattern, including long low stretches, so stalls hit the first cycle of a result as well as later ones. It judges that the held data never changes and that the scoreboard order of beats is preserved. The completion of the last output beat and the reopening of `in_ready` are also close together. The bench checks that the next vector is only taken afterward, with input gaps inserted at random and single-hot vectors chosen so that some sums land exactly on a threshold.

// File: rtl/qmvtu_pkg.sv
package qmvtu_pkg;

   localparam int ACT_W = 2;
   localparam int WGT_W = 2;

   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_CALC = 2'd1,
      ST_EMIT = 2'd2
   } eng_state_e;

   // fixed weight pattern held in every bank
   function automatic logic [WGT_W-1:0] wgt_code(input int row, input int col, input int seed);
      return WGT_W'((row * 3 + col * 5 + seed) % 4);
   endfunction

endpackage

// File: rtl/qmvtu_wbank.sv
module qmvtu_wbank
   import qmvtu_pkg::*;
#(
   parameter int SIMD   = 4,
   parameter int NF     = 3,
   parameter int SF     = 2,
   parameter int PE     = 2,
   parameter int PE_IDX = 0,
   parameter int SEED   = 1,
   parameter int AW     = 3
) (
   input  logic [AW-1:0]          rd_addr,
   output logic [SIMD*WGT_W-1:0]  wgt_vec
);
   localparam int DEPTH = NF * SF;

   logic [SIMD*WGT_W-1:0] rom [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      for (genvar j = 0; j < SIMD; j++) begin : g_lane
         assign rom[a][j*WGT_W +: WGT_W] =
            wgt_code((a / SF) * PE + PE_IDX, (a % SF) * SIMD + j, SEED);
      end
   end

   assign wgt_vec = rom[rd_addr];

endmodule

// File: rtl/qmvtu_pe.sv
module qmvtu_pe
   import qmvtu_pkg::*;
#(
   parameter int SIMD    = 4,
   parameter int ACC_W   = 8,
   parameter int THR_LO  = -2,
   parameter int THR_MID = 1,
   parameter int THR_HI  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    last,
   input  logic [SIMD*ACT_W-1:0]   act_vec,
   input  logic [SIMD*WGT_W-1:0]   wgt_vec,
   output logic [ACT_W-1:0]        level
);
   localparam logic signed [ACC_W-1:0] T_LO  = ACC_W'(THR_LO);
   localparam logic signed [ACC_W-1:0] T_MID = ACC_W'(THR_MID);
   localparam logic signed [ACC_W-1:0] T_HI  = ACC_W'(THR_HI);

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] psum;
   logic signed [ACC_W-1:0] total;
   logic [ACT_W-1:0]        level_d;

   always_comb begin
      psum = '0;
      for (int j = 0; j < SIMD; j++) begin
         logic signed [ACC_W-1:0] a_s;
         logic signed [ACC_W-1:0] w_s;
         logic [WGT_W-1:0]        w;
         w   = wgt_vec[j*WGT_W +: WGT_W];
         a_s = ACC_W'(act_vec[j*ACT_W +: ACT_W]);
         w_s = {{(ACC_W-WGT_W){w[WGT_W-1]}}, w};
         psum = psum + a_s * w_s;
      end
      total   = acc_q + psum;
      level_d = ACT_W'(total >= T_LO) + ACT_W'(total >= T_MID) + ACT_W'(total >= T_HI);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         level <= '0;
      end else if (step) begin
         if (last) begin
            acc_q <= '0;
            level <= level_d;
         end else begin
            acc_q <= total;
         end
      end
   end

endmodule

// File: rtl/qmvtu_engine.sv
module qmvtu_engine
   import qmvtu_pkg::*;
#(
   parameter int IN_DIM  = 8,
   parameter int OUT_DIM = 6,
   parameter int PE      = 2,
   parameter int SIMD    = 4,
   parameter int SEED    = 1,
   parameter int THR_LO  = -2,
   parameter int THR_MID = 1,
   parameter int THR_HI  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [SIMD*ACT_W-1:0] in_data,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [PE*ACT_W-1:0]   out_data
);
   localparam int SF    = IN_DIM / SIMD;
   localparam int NF    = OUT_DIM / PE;
   localparam int DEPTH = NF * SF;
   localparam int SFW   = (SF > 1) ? $clog2(SF) : 1;
   localparam int NFW   = (NF > 1) ? $clog2(NF) : 1;
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int ACC_W = $clog2(IN_DIM * 6 + 1) + 2;

   if (IN_DIM % SIMD != 0) begin : g_bad_simd
      $error("IN_DIM must be a multiple of SIMD");
   end
   if (OUT_DIM % PE != 0) begin : g_bad_pe
      $error("OUT_DIM must be a multiple of PE");
   end
   if (!(THR_LO < THR_MID && THR_MID < THR_HI)) begin : g_bad_thr
      $error("thresholds must be strictly ascending");
   end
   if (THR_HI >= 2 ** (ACC_W - 1) || THR_LO < -(2 ** (ACC_W - 1))) begin : g_bad_range
      $error("threshold outside accumulator range");
   end

   eng_state_e             state_q;
   logic [NFW-1:0]         nf_q;
   logic [SFW-1:0]         sf_q;
   logic [SFW-1:0]         beat_q;
   logic [SIMD*ACT_W-1:0]  act_buf [SF];
   logic                   sf_end;
   logic                   calc_en;
   logic                   calc_last;
   logic                   in_fire;
   logic                   out_fire;
   logic [AW-1:0]          rd_addr;
   logic [SIMD*ACT_W-1:0]  cur_act;

   assign in_ready  = (state_q == ST_LOAD);
   assign out_valid = (state_q == ST_EMIT);
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;
   assign calc_en   = (state_q == ST_CALC);
   assign calc_last = calc_en && sf_end;
   assign rd_addr   = AW'(int'(nf_q) * SF + int'(sf_q));
   assign cur_act   = act_buf[sf_q];

   // column-fold counters collapse when a single beat covers the vector
   if (SF == 1) begin : g_sf_one
      assign sf_q   = '0;
      assign beat_q = '0;
      assign sf_end = 1'b1;
   end else begin : g_sf_many
      assign sf_end = (sf_q == SFW'(SF - 1));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sf_q   <= '0;
            beat_q <= '0;
         end else begin
            if (calc_en) sf_q <= sf_end ? '0 : sf_q + 1'b1;
            if (in_fire) beat_q <= (beat_q == SFW'(SF - 1)) ? '0 : beat_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (in_fire) act_buf[beat_q] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_LOAD;
         nf_q    <= '0;
      end else begin
         unique case (state_q)
            ST_LOAD: if (in_fire && beat_q == SFW'(SF - 1)) state_q <= ST_CALC;
            ST_CALC: if (sf_end) state_q <= ST_EMIT;
            ST_EMIT: if (out_fire) begin
               if (nf_q == NFW'(NF - 1)) begin
                  nf_q    <= '0;
                  state_q <= ST_LOAD;
               end else begin
                  nf_q    <= nf_q + 1'b1;
                  state_q <= ST_CALC;
               end
            end
            default: state_q <= ST_LOAD;
         endcase
      end
   end

   for (genvar p = 0; p < PE; p++) begin : g_pe
      logic [SIMD*WGT_W-1:0] wgt_vec;

      qmvtu_wbank #(
         .SIMD(SIMD), .NF(NF), .SF(SF), .PE(PE),
         .PE_IDX(p), .SEED(SEED), .AW(AW)
      ) u_bank (
         .rd_addr (rd_addr),
         .wgt_vec (wgt_vec)
      );

      qmvtu_pe #(
         .SIMD(SIMD), .ACC_W(ACC_W),
         .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
      ) u_pe (
         .clk     (clk),
         .rst_n   (rst_n),
         .step    (calc_en),
         .last    (calc_last),
         .act_vec (cur_act),
         .wgt_vec (wgt_vec),
         .level   (out_data[p*ACT_W +: ACT_W])
      );
   end

endmodule

// File: rtl/qmvtu_engine_chk.sv
module qmvtu_engine_chk #(
   parameter int SF = 2,
   parameter int NF = 3,
   parameter int DW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data
);
   int unsigned in_cnt;
   int unsigned out_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cnt  <= 0;
         out_cnt <= 0;
      end else begin
         if (in_valid && in_ready) in_cnt <= (in_cnt == SF - 1) ? 0 : in_cnt + 1;
         if (out_valid && out_ready) out_cnt <= (out_cnt == NF - 1) ? 0 : out_cnt + 1;
      end
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R2
   capture_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_cnt == SF - 1) |=> !in_ready);

   // R6
   drain_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_cnt == NF - 1) |=> in_ready);

   // R6
   mid_fold_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_cnt != NF - 1) |=> !in_ready);

endmodule

bind qmvtu_engine qmvtu_engine_chk #(
   .SF(IN_DIM / SIMD), .NF(OUT_DIM / PE), .DW(PE * 2)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/qmvtu_engine_tb.sv
module qmvtu_engine_tb_top;
   localparam int IN_DIM  = 8;
   localparam int OUT_DIM = 6;
   localparam int PE      = 2;
   localparam int SIMD    = 4;
   localparam int SEED    = 1;
   localparam int THR_LO  = -2;
   localparam int THR_MID = 1;
   localparam int THR_HI  = 4;
   localparam int SF      = IN_DIM / SIMD;
   localparam int NF      = OUT_DIM / PE;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [SIMD*2-1:0]    in_data = '0;
   logic                 out_valid;
   logic                 out_ready = 1'b0;
   logic [PE*2-1:0]      out_data;

   int total = 0;
   int bad   = 0;
   int rdy_mode = 0;
   int gap_mode = 0;
   bit finished = 0;
   logic [PE*2-1:0] exp_q [$];

   always #10 clk = ~clk;

   qmvtu_engine #(
      .IN_DIM(IN_DIM), .OUT_DIM(OUT_DIM), .PE(PE), .SIMD(SIMD), .SEED(SEED),
      .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   function automatic int wval(int r, int c);
      int code;
      code = (3 * r + 5 * c + SEED) % 4;
      case (code)
         0: return 0;
         1: return 1;
         2: return -2;
         default: return -1;
      endcase
   endfunction

   function automatic logic [1:0] lvl(int s);
      int n;
      n = 0;
      if (s >= THR_LO)  n++;
      if (s >= THR_MID) n++;
      if (s >= THR_HI)  n++;
      return 2'(n);
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: queue expected beats, then stream the vector in
   task automatic run_vector(input logic [1:0] a [IN_DIM]);
      for (int k = 0; k < NF; k++) begin
         logic [PE*2-1:0] beat;
         for (int p = 0; p < PE; p++) begin
            int s;
            s = 0;
            for (int c = 0; c < IN_DIM; c++) s += int'(a[c]) * wval(k * PE + p, c);
            beat[p*2 +: 2] = lvl(s);
         end
         exp_q.push_back(beat);
      end
      for (int b = 0; b < SF; b++) begin
         @(negedge clk);
         if (gap_mode != 0) begin
            int g;
            g = int'($urandom % 3);
            in_valid = 1'b0;
            in_data  = '1;
            for (int i = 0; i < g; i++) @(negedge clk);
         end
         in_valid = 1'b1;
         for (int j = 0; j < SIMD; j++) in_data[j*2 +: 2] = a[b*SIMD + j];
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
      // R2: vector complete, input closed
      check(in_ready == 1'b0, "R2 in_ready after last beat", 32'(in_ready), 32'd0);
   endtask

   // monitor: drives out_ready, pops and compares on each accepted beat
   logic [PE*2-1:0] held;
   bit held_v = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         bit r;
         case (rdy_mode)
            0: r = 1'b1;
            1: r = ($urandom % 2) == 0;
            default: r = ($urandom % 5) == 0;
         endcase
         if (held_v) begin
            // R7: stalled beat must persist unchanged
            check(out_valid === 1'b1 && out_data === held, "R7 hold under stall",
                  32'({out_valid, out_data}), 32'({1'b1, held}));
         end
         held_v = out_valid && !r;
         held   = out_data;
         // R9
         if (in_ready && out_valid) check(1'b0, "R9 ready and valid together", 32'd1, 32'd0);
         out_ready = r;
         if (out_valid && r) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected extra beat", 32'(out_data), 32'd0);
            end else begin
               logic [PE*2-1:0] e;
               e = exp_q.pop_front();
               // R3 R4 R5 R6: level per row of this beat
               check(out_data === e, "R3/R4/R5/R6 output beat", 32'(out_data), 32'(e));
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] v [IN_DIM];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
      check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

      // all zeros and all threes
      for (int c = 0; c < IN_DIM; c++) v[c] = 2'd0;
      run_vector(v);
      for (int c = 0; c < IN_DIM; c++) v[c] = 2'd3;
      run_vector(v);
      // single-hot vectors put sums on thresholds exactly (R5)
      for (int h = 0; h < IN_DIM; h++) begin
         for (int c = 0; c < IN_DIM; c++) v[c] = (c == h) ? 2'd1 : 2'd0;
         run_vector(v);
      end
      // R8: gaps between beats, random data, random stalls (R7)
      gap_mode = 1;
      rdy_mode = 1;
      for (int n = 0; n < 12; n++) begin
         for (int c = 0; c < IN_DIM; c++) v[c] = 2'($urandom % 4);
         run_vector(v);
      end
      rdy_mode = 2;
      for (int n = 0; n < 8; n++) begin
         for (int c = 0; c < IN_DIM; c++) v[c] = (c % 2 == n % 2) ? 2'd3 : 2'($urandom % 4);
         run_vector(v);
      end
      rdy_mode = 0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
      // R7: nothing dropped, nothing repeated
      check(exp_q.size() == 0, "R7 scoreboard drained", 32'(exp_q.size()), 32'd0);
      check(out_valid == 1'b0, "R7 no trailing beat", 32'(out_valid), 32'd0);
      check(in_ready == 1'b1, "R6 input reopened", 32'(in_ready), 32'd1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule